// File: doc/BRIEF.md
# Trap Control Unit

This block is the privileged control unit that a small 32-bit processor consults whenever normal sequential fetch must be abandoned for the kernel. The pipeline presents a fault request with a 5-bit reason code, the PC of the offending instruction and an optional faulting data address. It also presents a system-call request and a timer request, which share that PC. On a taken trap the unit latches the return PC, the reason code and, for address-related faults, the bad address. It then raises kernel privilege, masks further traps and, in the same cycle, tells fetch to jump to the fixed handler entry point.

Handler software reaches the unit's four registers through a combinational read port and a write strobe. A return command sends fetch back to the saved PC and drops to user mode with traps re-enabled. A fault or system call that arrives while traps are masked is not allowed to overwrite the saved state. It is diverted to a separate double-fault entry point instead. One more fault after that freezes the unit in a shutdown state until reset.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After reset the unit is in kernel mode with traps masked, the double-fault and shutdown flags are clear, and the saved PC, reason and bad-address registers read as zero.
- R2: A request taken while traps are enabled asserts `redir_valid` in the same cycle with `redir_pc` = VEC_MAIN (default 0x8000_0180). At the next edge it stores the request PC as the saved PC and the selected reason code as the reason register.
- R3: The bad-address register loads `flt_addr` on a taken trap only when the reason is 4 (address error), 13 (page fault) or 14 (protection fault). Any other taken trap leaves it unchanged.
- R4: After a taken trap the unit is in kernel mode with traps masked.
- R5: Reason codes are: the fault's own code for a fault request, 8 for a system call and 0 for a timer tick. When several requests arrive in one cycle, fault beats system call, and system call beats tick.
- R6: A timer tick that arrives while traps are masked has no effect: there is no redirect and no state change.
- R7: A fault or system call that arrives while traps are masked and no double fault is pending sets `double_fault` and redirects to VEC_DOUBLE (default 0x8000_0300). The saved PC, reason and bad address are left untouched.
- R8: A fault or system call that arrives while a double fault is pending and traps are masked sets `shutdown`. It gives no redirect. Shutdown holds until reset, and every later request, return and write is then ignored.
- R9: A return command in kernel mode redirects to the saved PC in the same cycle. At the next edge it sets user mode, enables traps and clears `double_fault`. A return in user mode is ignored, and a trap in the same cycle wins over the return.
- R10: Register writes take effect only in kernel mode, with lower priority than a trap or a return. The selector codes are 0 = status (bit 0 trap enable, bit 1 kernel mode; bits 2 and 3 read-only), 1 = reason (bits 4:0), 2 = saved PC, 3 = bad address.
- R11: `csr_rdata` shows the selected register combinationally in kernel mode and reads zero in user mode. Status reads as {28'b0, shutdown, double_fault, kernel, enable}.
- R12: The saved PC, reason and bad-address registers change only on a taken trap or on a write to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_req | input | 1 | Fault request from the pipeline |
| flt_code | input | 5 | Reason code of the fault |
| trap_pc | input | 32 | PC of the instruction raising the request |
| flt_addr | input | 32 | Faulting data address |
| sys_req | input | 1 | System-call request |
| tick_req | input | 1 | Timer tick request |
| ret_req | input | 1 | Return-from-trap command |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register selector for read and write |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| redir_valid | output | 1 | Fetch must jump this cycle |
| redir_pc | output | 32 | Jump target |
| kernel_mode | output | 1 | Privilege level, 1 = kernel |
| trap_en | output | 1 | Traps enabled |
| double_fault | output | 1 | Double fault pending |
| shutdown | output | 1 | Unit halted until reset |

## Verification
The assertions assume that reset is applied before any request. They also assume that requests, return and write strobes are known values at every clock edge, and that a request holds its code, PC and address stable for the cycle in which it is raised. The stimulus drives every input shortly after the falling edge and keeps it until the next falling edge. It draws reason codes only from the defined set. It also re-applies reset every few hundred random cycles, so that long runs do not stay stuck in shutdown and the masked-trap and double-fault paths are entered many times.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_TICK    = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ADDR    = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL = 5'd8;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd10;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF     = 5'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_PAGE    = 5'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT    = 5'd14;
  localparam logic [CAUSE_W-1:0] CAUSE_DIV0    = 5'd15;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_BADV   = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic take;
    logic dbl;
    logic halt;
    logic ret;
    logic wr;
  } trap_act_t;

  function automatic logic cause_has_addr(input logic [CAUSE_W-1:0] c);
    return (c == CAUSE_ADDR) || (c == CAUSE_PAGE) || (c == CAUSE_PROT);
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic               flt_req,
  input  logic [CAUSE_W-1:0] flt_code,
  input  logic               sys_req,
  input  logic               tick_req,
  input  logic               ret_req,
  input  logic               csr_we,
  input  logic               kernel,
  input  logic               en,
  input  logic               dflt,
  input  logic               shut,
  output trap_act_t          act,
  output logic [CAUSE_W-1:0] code
);
  logic sync_any;

  always_comb begin
    sync_any = flt_req | sys_req;
    act      = '0;
    if (!shut) begin
      if (en && (sync_any || tick_req))   act.take = 1'b1;
      else if (!en && sync_any && !dflt)  act.dbl  = 1'b1;
      else if (!en && sync_any && dflt)   act.halt = 1'b1;
      else if (ret_req && kernel)         act.ret  = 1'b1;
      else if (csr_we && kernel)          act.wr   = 1'b1;
    end
  end

  always_comb begin
    if (flt_req)      code = flt_code;
    else if (sys_req) code = CAUSE_SYSCALL;
    else              code = CAUSE_TICK;
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trap_act_t act,
  input  csr_sel_e  wr_sel,
  input  logic [1:0] wr_bits,
  output logic      kernel_o,
  output logic      en_o,
  output logic      dflt_o,
  output logic      shut_o
);
  logic kernel_q, en_q, dflt_q, shut_q;
  logic kernel_d, en_d, dflt_d, shut_d;

  always_comb begin
    kernel_d = kernel_q;
    en_d     = en_q;
    dflt_d   = dflt_q;
    shut_d   = shut_q;
    if (act.halt) begin
      shut_d = 1'b1;
    end else if (act.take) begin
      kernel_d = 1'b1;
      en_d     = 1'b0;
    end else if (act.dbl) begin
      dflt_d   = 1'b1;
      kernel_d = 1'b1;
      en_d     = 1'b0;
    end else if (act.ret) begin
      kernel_d = 1'b0;
      en_d     = 1'b1;
      dflt_d   = 1'b0;
    end else if (act.wr && wr_sel == SEL_STATUS) begin
      en_d     = wr_bits[0];
      kernel_d = wr_bits[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kernel_q <= 1'b1;
      en_q     <= 1'b0;
      dflt_q   <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      kernel_q <= kernel_d;
      en_q     <= en_d;
      dflt_q   <= dflt_d;
      shut_q   <= shut_d;
    end
  end

  assign kernel_o = kernel_q;
  assign en_o     = en_q;
  assign dflt_o   = dflt_q;
  assign shut_o   = shut_q;

  assert_take_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act.take |=> (kernel_q && !en_q));
  assert_ret_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act.ret |=> (!kernel_q && en_q && !dflt_q));
  assert_dbl_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act.dbl |=> dflt_q);
  assert_shut_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |=> shut_q);
endmodule

// File: rtl/trap_regfile.sv
module trap_regfile
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  trap_act_t          act,
  input  logic [CAUSE_W-1:0] code,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    addr_i,
  input  csr_sel_e           sel,
  input  logic [XLEN-1:0]    wdata,
  input  logic [3:0]         status_bits,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    rdata
);
  logic [XLEN-1:0]    epc_q, epc_d, badv_q, badv_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic wr_epc, wr_cause, wr_badv;

  always_comb begin
    wr_epc   = act.wr && (sel == SEL_EPC);
    wr_cause = act.wr && (sel == SEL_CAUSE);
    wr_badv  = act.wr && (sel == SEL_BADV);
    epc_d    = epc_q;
    cause_d  = cause_q;
    badv_d   = badv_q;
    if (act.take) begin
      epc_d   = pc_i;
      cause_d = code;
      if (cause_has_addr(code)) badv_d = addr_i;
    end else begin
      if (wr_epc)   epc_d   = wdata;
      if (wr_cause) cause_d = wdata[CAUSE_W-1:0];
      if (wr_badv)  badv_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      badv_q  <= '0;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
      badv_q  <= badv_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata = {{(XLEN-4){1'b0}}, status_bits};
      SEL_CAUSE:  rdata = {{(XLEN-CAUSE_W){1'b0}}, cause_q};
      SEL_EPC:    rdata = epc_q;
      default:    rdata = badv_q;
    endcase
  end

  assign epc_o = epc_q;

  assert_epc_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act.take |=> (epc_q == $past(pc_i)));
  assert_epc_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.take || wr_epc) |=> $stable(epc_q));
  assert_cause_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.take || wr_cause) |=> $stable(cause_q));
  assert_badv_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act.take && !cause_has_addr(code) && !wr_badv) |=> $stable(badv_q));
endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_MAIN   = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_DOUBLE = 32'h8000_0300
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_req,
  input  logic [CAUSE_W-1:0] flt_code,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    flt_addr,
  input  logic               sys_req,
  input  logic               tick_req,
  input  logic               ret_req,
  input  logic               csr_we,
  input  logic [1:0]         csr_sel,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic               kernel_mode,
  output logic               trap_en,
  output logic               double_fault,
  output logic               shutdown
);
  trap_act_t          act;
  logic [CAUSE_W-1:0] code;
  logic [XLEN-1:0]    epc, raw_rdata;
  csr_sel_e           sel;

  assign sel = csr_sel_e'(csr_sel);

  trap_arbiter u_arb (
    .flt_req (flt_req),  .flt_code(flt_code), .sys_req(sys_req),
    .tick_req(tick_req), .ret_req (ret_req),  .csr_we (csr_we),
    .kernel  (kernel_mode), .en(trap_en), .dflt(double_fault),
    .shut    (shutdown), .act(act), .code(code)
  );

  trap_status u_st (
    .clk(clk), .rst_n(rst_n), .act(act), .wr_sel(sel),
    .wr_bits(csr_wdata[1:0]), .kernel_o(kernel_mode), .en_o(trap_en),
    .dflt_o(double_fault), .shut_o(shutdown)
  );

  trap_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .act(act), .code(code), .pc_i(trap_pc),
    .addr_i(flt_addr), .sel(sel), .wdata(csr_wdata),
    .status_bits({shutdown, double_fault, kernel_mode, trap_en}),
    .epc_o(epc), .rdata(raw_rdata)
  );

  always_comb begin
    redir_valid = act.take | act.dbl | act.ret;
    if (act.take)     redir_pc = VEC_MAIN;
    else if (act.dbl) redir_pc = VEC_DOUBLE;
    else              redir_pc = epc;
  end

  assign csr_rdata = kernel_mode ? raw_rdata : '0;

  assert_halt_no_redir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !redir_valid);
  assert_user_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel_mode |-> (csr_rdata == '0));
endmodule

// File: tb/sim_trap_ctrl_unit.sv
module sim_trap_ctrl_unit;
  localparam logic [31:0] VMAIN = 32'h8000_0180;
  localparam logic [31:0] VDBL  = 32'h8000_0300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flt_req, sys_req, tick_req, ret_req, csr_we;
  logic [4:0] flt_code;
  logic [31:0] trap_pc, flt_addr, csr_wdata, csr_rdata, redir_pc;
  logic [1:0] csr_sel;
  logic redir_valid, kernel_mode, trap_en, double_fault, shutdown;

  trap_ctrl_unit u0 (
    .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_code(flt_code),
    .trap_pc(trap_pc), .flt_addr(flt_addr), .sys_req(sys_req),
    .tick_req(tick_req), .ret_req(ret_req), .csr_we(csr_we),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .kernel_mode(kernel_mode),
    .trap_en(trap_en), .double_fault(double_fault), .shutdown(shutdown)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_k, m_en, m_df, m_sh;
  logic [31:0] m_epc, m_badv;
  logic [4:0] m_cause;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] s);
    if (!m_k) return 32'h0;
    case (s)
      2'd0: return {28'h0, m_sh, m_df, m_k, m_en};
      2'd1: return {27'h0, m_cause};
      2'd2: return m_epc;
      default: return m_badv;
    endcase
  endfunction

  function automatic logic [4:0] pick_code(int unsigned i);
    case (i % 8)
      0: return 5'd0;  1: return 5'd4;  2: return 5'd8;  3: return 5'd10;
      4: return 5'd12; 5: return 5'd13; 6: return 5'd14; default: return 5'd15;
    endcase
  endfunction

  task automatic check_state(string tag);
    chk(tag, "kernel_mode", {31'h0, kernel_mode}, {31'h0, m_k});
    chk(tag, "trap_en", {31'h0, trap_en}, {31'h0, m_en});
    chk(tag, "double_fault", {31'h0, double_fault}, {31'h0, m_df});
    chk(tag, "shutdown", {31'h0, shutdown}, {31'h0, m_sh});
    chk("R11", "csr_rdata", csr_rdata, m_read(csr_sel));
  endtask

  task automatic idle();
    flt_req = 0; sys_req = 0; tick_req = 0; ret_req = 0; csr_we = 0;
    flt_code = 0; trap_pc = 0; flt_addr = 0; csr_wdata = 0;
  endtask

  // One cycle: drive after falling edge, check redirect, clock, check state.
  task automatic cycle(logic fr, logic [4:0] fc, logic [31:0] fp, logic [31:0] fa,
                       logic sr, logic tr, logic er, logic wr, logic [1:0] ws,
                       logic [31:0] wd, string tag);
    logic syn, tk, db, hl, rt, wo;
    logic [4:0] cd;
    string rtag;
    flt_req = fr; flt_code = fc; trap_pc = fp; flt_addr = fa; sys_req = sr;
    tick_req = tr; ret_req = er; csr_we = wr; csr_sel = ws; csr_wdata = wd;
    #1;
    syn = fr | sr;
    tk = 0; db = 0; hl = 0; rt = 0; wo = 0;
    if (!m_sh) begin
      if (m_en && (syn || tr)) tk = 1;
      else if (!m_en && syn && !m_df) db = 1;
      else if (!m_en && syn && m_df) hl = 1;
      else if (er && m_k) rt = 1;
      else if (wr && m_k) wo = 1;
    end
    cd = fr ? fc : (sr ? 5'd8 : 5'd0);
    rtag = tk ? "R2" : db ? "R7" : rt ? "R9" : hl ? "R8" : "R6";
    chk(rtag, "redir_valid", {31'h0, redir_valid}, {31'h0, tk | db | rt});
    if (tk) chk(rtag, "redir_pc", redir_pc, VMAIN);
    if (db) chk(rtag, "redir_pc", redir_pc, VDBL);
    if (rt) chk(rtag, "redir_pc", redir_pc, m_epc);
    @(posedge clk);
    if (hl) m_sh = 1;
    else if (tk) begin
      m_k = 1; m_en = 0; m_epc = fp; m_cause = cd;
      if (cd == 5'd4 || cd == 5'd13 || cd == 5'd14) m_badv = fa;
    end else if (db) begin m_df = 1; m_k = 1; m_en = 0; end
    else if (rt) begin m_k = 0; m_en = 1; m_df = 0; end
    else if (wo) begin
      case (ws)
        2'd0: begin m_en = wd[0]; m_k = wd[1]; end
        2'd1: m_cause = wd[4:0];
        2'd2: m_epc = wd;
        default: m_badv = wd;
      endcase
    end
    @(negedge clk);
    idle();
    check_state(tag);
  endtask

  task automatic rd(logic [1:0] s, logic [31:0] exp, string tag, string what);
    csr_sel = s; #1;
    chk(tag, what, csr_rdata, exp);
  endtask

  task automatic do_reset();
    idle(); csr_sel = 0; rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    m_k = 1; m_en = 0; m_df = 0; m_sh = 0; m_epc = 0; m_badv = 0; m_cause = 0;
    check_state("R1");
    for (int s = 0; s < 4; s++) rd(2'(s), (s == 0) ? 32'h2 : 32'h0, "R1", "reset reg");
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R10: kernel writes, then drop to user with traps enabled
    cycle(0,0,0,0,0,0,0,1,2'd2,32'h0000_1000,"R10");
    rd(2'd2, 32'h0000_1000, "R10", "epc written");
    cycle(0,0,0,0,0,0,0,1,2'd0,32'h1,"R10");
    chk("R10", "user mode", {31'h0, kernel_mode}, 32'h0);
    rd(2'd2, 32'h0, "R11", "user read");
    // R10: user write of status ignored
    cycle(0,0,0,0,0,0,0,1,2'd0,32'h2,"R10");
    chk("R10", "user write ignored", {31'h0, kernel_mode}, 32'h0);
    // R2 R3 R4: page fault
    cycle(1,5'd13,32'h0000_0400,32'hABCD_0000,0,0,0,0,2'd3,0,"R4");
    rd(2'd2, 32'h0000_0400, "R2", "epc");
    rd(2'd1, 32'd13, "R2", "cause");
    rd(2'd3, 32'hABCD_0000, "R3", "badvaddr");
    // R6: masked tick ignored
    cycle(0,0,32'h0000_0500,0,0,1,0,0,2'd2,0,"R6");
    rd(2'd2, 32'h0000_0400, "R12", "epc kept");
    // R9: return
    cycle(0,0,0,0,0,0,1,0,2'd0,0,"R9");
    chk("R9", "user after return", {30'h0, kernel_mode, trap_en}, 32'h1);
    // R5: syscall beats tick
    cycle(0,0,32'h0000_0600,0,1,1,0,0,2'd1,0,"R5");
    rd(2'd1, 32'd8, "R5", "syscall cause");
    cycle(0,0,0,0,0,0,1,0,2'd0,0,"R9");
    // R5 R3: fault beats syscall, divide-by-zero keeps badvaddr
    cycle(1,5'd15,32'h0000_0700,32'h1111_1111,1,0,0,0,2'd3,0,"R5");
    rd(2'd1, 32'd15, "R5", "fault cause");
    rd(2'd3, 32'hABCD_0000, "R3", "badvaddr kept");
    // R7: syscall inside handler
    cycle(0,0,32'h0000_0800,0,1,0,0,0,2'd2,0,"R7");
    rd(2'd2, 32'h0000_0700, "R7", "epc preserved");
    chk("R7", "double_fault", {31'h0, double_fault}, 32'h1);
    // R8: fault during double fault, then everything ignored
    cycle(1,5'd12,32'h0000_0900,0,0,0,0,0,2'd0,0,"R8");
    chk("R8", "shutdown", {31'h0, shutdown}, 32'h1);
    cycle(0,0,0,0,0,0,1,0,2'd0,0,"R8");
    cycle(0,0,0,0,0,0,0,1,2'd2,32'hDEAD_0000,"R8");
    rd(2'd2, 32'h0000_0700, "R8", "epc after shutdown write");
    // Random phase
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if (i % 400 == 399) do_reset();
      cycle((r % 100) < 12, pick_code($urandom), $urandom & 32'hFFFF_FFFC, $urandom,
            ((r >> 8) % 100) < 8, ((r >> 16) % 100) < 10, ((r >> 24) % 100) < 25,
            ($urandom % 100) < 20, 2'($urandom), $urandom, "R12");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule